// File: doc/BRIEF.md
# Cursor and Crosshair Overlay Generator

This block sits beside the video timing chain. Each clock it produces the overlay code for a group of adjacent screen pixels. Two sources feed it. The first is a 64x64 two-plane bitmap cursor, read from an external 512-word pattern memory. The second is a crosshair made of one vertical and one horizontal line. The crosshair is centred on the cursor origin, its thickness is programmable, and it is clipped to a rectangular window.

A pixel group is one, four or five pixels wide, depending on the pixel multiplex mode. Each pixel receives a 2-bit overlay code, which a later colour stage turns into a colour. The cursor and the crosshair are merged by OR or by XOR.

The pixel and line counters are compared with the programmed positions after a horizontal skew that depends on the multiplex mode, and after a fixed vertical skew. All coordinate arithmetic wraps modulo 4096, so a cursor or crosshair can hang over the top or the left edge of the counter range. Pattern words are fetched two at a time: the word that holds the first pixel of the group, and the word after it. Every output therefore has a fixed latency of two clocks.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst_n` is low, `ovl` is all zeros. It is cleared as soon as reset is asserted, including in the middle of operation.
- R2: The `ovl` value that follows a rising clock edge reflects the inputs sampled two rising edges earlier. The pattern words for those inputs are expected on `mem_data_a` and `mem_data_b` one clock after their addresses.
- R3: `cmd[3:2]` selects the group width: 00 gives 1 pixel, 01 gives 4, 10 gives 5, and 11 behaves like 00. Pixel `pix_x+k` of a group appears on `ovl[2k+1:2k]`. Lanes beyond the group width are 00.
- R4: The skew P is 37 for modes 00 and 11, 52 for mode 01, and 57 for mode 10. The cursor column is (x + P - cur_x) mod 4096 and the cursor row is (y + 32 - cur_y) mod 4096. A pixel is inside the cursor when both values are below 64.
- R5: Cursor row r uses words r*8 to r*8+7. Column c is held in word r*8 + c/8, at bit 15-(c mod 8) of the mask plane (upper byte) and bit 7-(c mod 8) of the data plane (lower byte). `mem_addr_a` addresses the word that holds column (lane-0 column mod 64). `mem_addr_b` addresses the next word in the same row, wrapping within the row.
- R6: The cursor contributes {mask bit, data bit} when `cmd[6]` is 1 and the pixel is inside the cursor. Otherwise it contributes 00.
- R7: With `cmd[5]` set, let t = `cmd[1:0]`, so the line thickness is 2t+1 pixels. Pixel (x,y) lies on the crosshair when the circular distance from x to (cur_x - P) is at most t, or when the circular distance from y to (cur_y - 32) is at most t.
- R8: A crosshair pixel is shown only if (x - (win_x - P)) mod 4096 < `win_w` and (y - (win_y - 32)) mod 4096 < `win_h`. A window with zero width or zero height shows no crosshair.
- R9: A shown crosshair pixel has the value 11. It is merged with the cursor value by bitwise OR when `cmd[4]` is 1, and by bitwise XOR when `cmd[4]` is 0.
- R10: With `cmd[6]` and `cmd[5]` both 0, every lane of `ovl` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 7 | Enables, merge mode, multiplex mode, thickness |
| pix_x | input | 12 | Pixel counter of lane 0 of the group |
| line_y | input | 12 | Scanline counter |
| cur_x | input | 12 | Cursor X position |
| cur_y | input | 12 | Cursor Y position |
| win_x | input | 12 | Crosshair window X |
| win_y | input | 12 | Crosshair window Y |
| win_w | input | 12 | Crosshair window width |
| win_h | input | 12 | Crosshair window height |
| mem_addr_a | output | 9 | Pattern address, word of lane 0 |
| mem_data_a | input | 16 | Pattern word for `mem_addr_a`, one clock later |
| mem_addr_b | output | 9 | Pattern address, following word |
| mem_data_b | input | 16 | Pattern word for `mem_addr_b`, one clock later |
| ovl | output | 10 | Five 2-bit overlay codes, lane 0 in the low bits |

## Verification
The cursor is swept in every multiplex mode. In the 4:1 and 5:1 modes the group start is not a multiple of eight, so some groups take pixels from both fetched words. A 1:1 sweep would not separate the two memory ports, and this one does.

A second sweep places the cursor origin below zero in both axes. It tells correct modulo arithmetic apart from saturating or sign-dropping arithmetic. The crosshair is scanned at all four thicknesses with a window that cuts both lines, which shows the symmetric widening and both clip edges. Zero-width and zero-height windows are tried separately.

Overlapping cursor and crosshair scans with `cmd[4]` set and then cleared tell the OR merge from the XOR merge. A scan with both sources disabled, and a reset applied mid-scan, close the run.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CW = 12,
  parameter int CSIZE = 64,
  parameter int LANES = 5,
  parameter int SKEW_1 = 37,
  parameter int SKEW_4 = 52,
  parameter int SKEW_5 = 57,
  parameter int VSKEW = 32,
  localparam int CB = $clog2(CSIZE),
  localparam int AW = 2 * CB - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [6:0]           cmd,
  input  logic [CW-1:0]        pix_x,
  input  logic [CW-1:0]        line_y,
  input  logic [CW-1:0]        cur_x,
  input  logic [CW-1:0]        cur_y,
  input  logic [CW-1:0]        win_x,
  input  logic [CW-1:0]        win_y,
  input  logic [CW-1:0]        win_w,
  input  logic [CW-1:0]        win_h,
  output logic [AW-1:0]        mem_addr_a,
  input  logic [15:0]          mem_data_a,
  output logic [AW-1:0]        mem_addr_b,
  input  logic [15:0]          mem_data_b,
  output logic [2*LANES-1:0]   ovl
);
  localparam int WB = CB - 3;

  logic [1:0]    mux;
  logic [CW-1:0] skew;
  logic [2:0]    nlanes;
  logic [CW-1:0] d0, row, hx, vy, dy, wx0, wy0;
  logic [CW-1:0] half;
  logic          row_in, on_h, win_y_ok;
  logic          or_q;

  assign mux = cmd[3:2];

  always_comb begin
    case (mux)
      2'b01:   begin skew = CW'(SKEW_4); nlanes = 3'd4; end
      2'b10:   begin skew = CW'(SKEW_5); nlanes = 3'd5; end
      default: begin skew = CW'(SKEW_1); nlanes = 3'd1; end
    endcase
  end

  assign half     = CW'(cmd[1:0]);
  assign d0       = pix_x + skew - cur_x;
  assign row      = line_y + CW'(VSKEW) - cur_y;
  assign row_in   = row < CW'(CSIZE);
  assign hx       = cur_x - skew;
  assign vy       = cur_y - CW'(VSKEW);
  assign dy       = line_y - vy;
  assign on_h     = (dy <= half) || ((CW'(0) - dy) <= half);
  assign wx0      = win_x - skew;
  assign wy0      = win_y - CW'(VSKEW);
  assign win_y_ok = (line_y - wy0) < win_h;

  assign mem_addr_a = {row[CB-1:0], d0[CB-1:3]};
  assign mem_addr_b = {row[CB-1:0], d0[CB-1:3] + WB'(1)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) or_q <= 1'b0;
    else        or_q <= cmd[4];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CW-1:0] px, col, dx;
    logic [3:0]    sub;
    logic          on_v, win_ok, act;
    logic          cur_q, xh_q, selb_q;
    logic [2:0]    bit_q;
    logic [15:0]   word;
    logic [1:0]    cv, xv, q;

    assign px     = pix_x + CW'(k);
    assign col    = d0 + CW'(k);
    assign dx     = px - hx;
    assign on_v   = (dx <= half) || ((CW'(0) - dx) <= half);
    assign win_ok = ((px - wx0) < win_w) && win_y_ok;
    assign act    = 3'(k) < nlanes;
    assign sub    = {1'b0, d0[2:0]} + 4'(k);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cur_q  <= 1'b0;
        xh_q   <= 1'b0;
        selb_q <= 1'b0;
        bit_q  <= 3'd0;
      end else begin
        cur_q  <= act && cmd[6] && row_in && (col < CW'(CSIZE));
        xh_q   <= act && cmd[5] && win_ok && (on_v || on_h);
        selb_q <= sub[3];
        bit_q  <= sub[2:0];
      end

    assign word = selb_q ? mem_data_b : mem_data_a;
    assign cv   = cur_q ? {word[4'd15 - {1'b0, bit_q}], word[4'd7 - {1'b0, bit_q}]} : 2'b00;
    assign xv   = {2{xh_q}};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) q <= 2'b00;
      else        q <= or_q ? (cv | xv) : (cv ^ xv);

    assign ovl[2*k +: 2] = q;
  end
endmodule

module cursor_overlay_chk #(
  parameter int CW = 12,
  parameter int LANES = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [6:0]         cmd,
  input logic [CW-1:0]      win_w,
  input logic [CW-1:0]      win_h,
  input logic [2*LANES-1:0] ovl
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> ovl == '0); // R1

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd[3:2], 2) == 2'b00 || $past(cmd[3:2], 2) == 2'b11)
    |-> ovl[2*LANES-1:2] == '0); // R3

  AST_FOUR_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd[3:2], 2) == 2'b01 |-> ovl[2*LANES-1:8] == '0); // R3

  AST_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd[6:5], 2) == 2'b00 |-> ovl == '0); // R10

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cmd[6] && (win_w == '0 || win_h == '0), 2) |-> ovl == '0); // R8
endmodule

bind cursor_overlay cursor_overlay_chk #(.CW(CW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .win_w(win_w), .win_h(win_h), .ovl(ovl)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cmd = '0;
  logic [11:0] pix_x = '0, line_y = '0, cur_x = '0, cur_y = '0;
  logic [11:0] win_x = '0, win_y = '0, win_w = '0, win_h = '0;
  logic [8:0]  mem_addr_a, mem_addr_b;
  logic [15:0] mem_data_a = '0, mem_data_b = '0;
  logic [9:0]  ovl;

  logic [15:0] mem [512];
  logic [9:0]  expq [$];
  int checks = 0, errors = 0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .pix_x(pix_x), .line_y(line_y),
    .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
    .win_w(win_w), .win_h(win_h), .mem_addr_a(mem_addr_a), .mem_data_a(mem_data_a),
    .mem_addr_b(mem_addr_b), .mem_data_b(mem_data_b), .ovl(ovl)
  );

  always @(posedge clk) begin
    mem_data_a <= mem[mem_addr_a];
    mem_data_b <= mem[mem_addr_b];
  end

  function automatic int lanes_of(logic [1:0] m);
    return (m == 2'b01) ? 4 : (m == 2'b10) ? 5 : 1;
  endfunction

  function automatic logic [1:0] ref_px(logic [11:0] x, logic [11:0] y);
    logic [11:0] p, col, row, dx, dy, t;
    logic [15:0] w;
    logic [1:0] cv, xv;
    logic onv, onh, inw;
    int c3;
    p = (cmd[3:2] == 2'b01) ? 12'd52 : (cmd[3:2] == 2'b10) ? 12'd57 : 12'd37;
    col = x + p - cur_x;
    row = y + 12'd32 - cur_y;
    cv = 2'b00;
    if (cmd[6] && col < 12'd64 && row < 12'd64) begin
      w  = mem[int'(row) * 8 + int'(col) / 8];
      c3 = int'(col) % 8;
      cv = {w[15 - c3], w[7 - c3]};
    end
    t   = 12'(cmd[1:0]);
    dx  = x - (cur_x - p);
    dy  = y - (cur_y - 12'd32);
    onv = (dx <= t) || ((12'd0 - dx) <= t);
    onh = (dy <= t) || ((12'd0 - dy) <= t);
    inw = ((x - (win_x - p)) < win_w) && ((y - (win_y - 12'd32)) < win_h);
    xv  = (cmd[5] && inw && (onv || onh)) ? 2'b11 : 2'b00;
    return cmd[4] ? (cv | xv) : (cv ^ xv);
  endfunction

  function automatic logic [9:0] ref_vec();
    logic [9:0] v = '0;
    for (int k = 0; k < lanes_of(cmd[3:2]); k++)
      v[2*k +: 2] = ref_px(pix_x + 12'(k), line_y);
    return v;
  endfunction

  task automatic check_out(int need);
    logic [9:0] e;
    if (expq.size() >= need) begin
      e = expq.pop_front();
      checks++;
      if (ovl !== e) begin
        errors++;
        $display("FAIL %s: ovl=%b expected %b", phase, ovl, e);
      end
    end
  endtask

  task automatic step(logic [11:0] px, logic [11:0] ly);
    @(negedge clk);
    check_out(2);
    pix_x  = px;
    line_y = ly;
    expq.push_back(ref_vec());
  endtask

  task automatic flush();
    @(negedge clk);
    check_out(2);
    @(negedge clk);
    check_out(1);
  endtask

  task automatic scan(int x0, int y0, int ncl, int nln);
    int nl = lanes_of(cmd[3:2]);
    for (int y = 0; y < nln; y++)
      for (int j = 0; j < ncl; j++)
        step(12'((x0 + j * nl) & 4095), 12'((y0 + y) & 4095));
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++)
      mem[i] = 16'((i * 40503) ^ (i << 4) ^ 16'h5a3c);

    repeat (3) begin
      @(negedge clk);
      checks++;
      if (ovl !== '0) begin
        errors++;
        $display("FAIL R1: ovl=%b expected %b", ovl, 10'b0);
      end
    end
    rst_n = 1'b1;

    phase = "R2 R3 R4 R5 R6 cursor 1:1";
    cmd = 7'h40; cur_x = 12'd300; cur_y = 12'd200;
    scan(258, 165, 72, 70);

    phase = "R3 R5 R6 cursor 4:1 unaligned";
    cmd = 7'h44;
    scan(245, 165, 19, 70);

    phase = "R3 R5 R6 cursor 5:1 unaligned";
    cmd = 7'h48;
    scan(239, 165, 15, 70);

    phase = "R3 reserved mode as 1:1";
    cmd = 7'h4C;
    scan(258, 166, 12, 6);

    phase = "R4 origin wraps below zero";
    cmd = 7'h40; cur_x = 12'd10; cur_y = 12'd5;
    scan(4064, 4064, 72, 70);

    cur_x = 12'd400; cur_y = 12'd300;
    win_x = 12'd380; win_y = 12'd290; win_w = 12'd40; win_h = 12'd20;
    for (int t = 0; t < 4; t++) begin
      phase = $sformatf("R7 R8 crosshair thickness %0d", 2 * t + 1);
      cmd = 7'h24 | 7'(t);
      scan(320, 250, 15, 30);
    end

    phase = "R8 zero width window";
    cmd = 7'h25; win_w = 12'd0;
    scan(320, 260, 15, 10);
    phase = "R8 zero height window";
    win_w = 12'd40; win_h = 12'd0;
    scan(320, 260, 15, 10);

    cur_x = 12'd300; cur_y = 12'd200;
    win_x = 12'd0; win_y = 12'd0; win_w = 12'hFFF; win_h = 12'hFFF;
    phase = "R9 OR merge";
    cmd = 7'h71;
    scan(255, 160, 30, 20);
    phase = "R9 XOR merge";
    cmd = 7'h61;
    scan(255, 160, 30, 20);
    phase = "R9 XOR merge 5:1 thick";
    cmd = 7'h6B;
    scan(250, 160, 8, 20);

    phase = "R10 both sources off";
    cmd = 7'h0B;
    scan(255, 160, 10, 10);

    phase = "R1 reset mid scan";
    cmd = 7'h73;
    for (int j = 0; j < 6; j++) step(12'(262 + j), 12'd169);
    @(negedge clk);
    rst_n = 1'b0;
    expq.delete();
    @(negedge clk);
    checks++;
    if (ovl !== '0) begin
      errors++;
      $display("FAIL R1: ovl=%b expected %b", ovl, 10'b0);
    end
    rst_n = 1'b1;
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule